// File: doc/BRIEF.md
# Power-Management Wake Signal Controller

This block decides when a network device drives its active-low, open-drain power-management wake line. Wake events arrive from elsewhere as single-cycle pulses: a magic packet, a link coming up, a matched wakeup frame. Any of them sets a sticky status bit. The status bit is cleared only when software writes a one to its position in the power-management control/status register. The block also holds the device power state (D0 to D3hot), which software writes through the same register. A state change takes effect at the next clock edge, with no enforced settling delay.

The wake line is driven only when all of the following hold:
- the status bit is set;
- the device-level wake enable is on;
- the register-level wake enable is on;
- the wake-support mask allows the current power state.

When the device runs on auxiliary power (isolation), the mask bit for D3cold decides instead of the one for the current state. In ACPI mode a wake from D0 is never signalled. I/O and memory decoding are turned off in every state other than D0, and also during isolation.

The open-drain pin is modelled as an output enable: when `pme_oe` is 1, the pad drives the line low. All outputs are registered. Reset returns the block to D0 with the status bit and both enables cleared.

Top module: `pm_event_ctrl`

## Requirements
- R1: After reset, `pme_status`=0, `pme_enable`=0, `pwr_state`=0 (D0), `pme_oe`=0, and `io_dec_en`=`mem_dec_en`=1. A reset taken in any power state returns `pwr_state` to D0.
- R2: A 1 on any bit of `wake_evt` sets `pme_status` at the next clock edge.
- R3: `pme_status` stays set across cycles with no event. It also stays set across register writes whose bit 15 is 0.
- R4: A register write with bit 15 = 1 clears `pme_status` at the next edge. If a wake event arrives in the same cycle, the event wins and the bit stays set.
- R5: A register write loads `pme_enable` from bit 8 and `pwr_state` from bits 1:0 (0=D0, 1=D1, 2=D2, 3=D3hot). Both take effect at the next edge.
- R6: `pme_oe` is 1 exactly one cycle after `pme_status`, `dev_pme_en`, `pme_enable` and the wake-support condition (R7/R8) are all true. If any of them is false, `pme_oe` is 0 one cycle later.
- R7: Wake support comes from `pmc_wake_mask`, bit i for state i (bit 0 D0 up to bit 3 D3hot). This field corresponds to capability bits 11 to 14. While `isolated` is 1, `pmc_wake_mask[4]` (the D3cold bit, capability bit 15) is used instead.
- R8: While `acpi_mode` is 1 and the device is in D0 and not isolated, wake is unsupported whatever `pmc_wake_mask[0]` holds. ACPI mode does not affect the other states.
- R9: `io_dec_en` and `mem_dec_en` are 1 one cycle after `pwr_state` is D0 with `isolated`=0, and 0 one cycle after any other combination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wake_evt | input | N_WAKE | Wake event pulses (magic packet, link-up, wakeup frame) |
| dev_pme_en | input | 1 | Device-level wake enable from configuration |
| pmcsr_wr | input | 1 | Write strobe for the control/status register |
| pmcsr_wdata | input | 16 | Write data: bits 1:0 state, bit 8 enable, bit 15 write-one-to-clear status |
| pmc_wake_mask | input | 5 | Wake-support mask, bit 0 D0 to bit 4 D3cold |
| acpi_mode | input | 1 | ACPI mode: no wake from D0 |
| isolated | input | 1 | Device on auxiliary power (D3cold isolation) |
| pme_oe | output | 1 | Open-drain drive enable; 1 pulls the wake line low |
| pme_status | output | 1 | Sticky wake status |
| pme_enable | output | 1 | Register-level wake enable |
| pwr_state | output | 2 | Current power state |
| io_dec_en | output | 1 | I/O decode enable |
| mem_dec_en | output | 1 | Memory decode enable |

## Verification
The checker watches several rules on every cycle:
- an event always sets the status bit;
- a clear without a concurrent event always empties it;
- the status bit never drops without a clear;
- the pin is never driven without a prior set status and both enables;
- the pin never drives from D0 in ACPI mode;
- decode is never enabled outside D0;
- a register write always lands in the state.

Whether the support mask picks the correct bit for each state and for isolation can only be shown by the bench. So can the exact expected pin level across combinations of enables and mask, and the event-versus-clear collision.

// File: rtl/pm_event_pkg.sv
package pm_event_pkg;
  typedef enum logic [1:0] {
    PS_D0    = 2'd0,
    PS_D1    = 2'd1,
    PS_D2    = 2'd2,
    PS_D3HOT = 2'd3
  } pstate_e;

  localparam int CSR_W      = 16;
  localparam int CSR_EN_BIT = 8;
  localparam int CSR_ST_BIT = 15;
  localparam int STATE_W    = 2;
  localparam int N_SUPPORT  = 5;
  localparam int COLD_IDX   = N_SUPPORT - 1;
endpackage

// File: rtl/pm_status_reg.sv
module pm_status_reg #(
  parameter int N_WAKE = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_WAKE-1:0] wake_evt,
  input  logic              clr_req,
  output logic              status
);
  logic any_evt;

  always_comb begin
    any_evt = 1'b0;
    for (int i = 0; i < N_WAKE; i++) begin
      any_evt = any_evt | wake_evt[i];
    end
  end

  // Events dominate a coincident clear so no wake is lost.
  always_ff @(posedge clk) begin
    if (rst) begin
      status <= 1'b0;
    end else if (any_evt) begin
      status <= 1'b1;
    end else if (clr_req) begin
      status <= 1'b0;
    end
  end
endmodule

// File: rtl/pm_csr_reg.sv
module pm_csr_reg
  import pm_event_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr,
  input  logic [CSR_W-1:0]     wdata,
  output logic                 pme_en,
  output logic [STATE_W-1:0]   state,
  output logic                 clr_req
);
  assign clr_req = wr & wdata[CSR_ST_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      pme_en <= 1'b0;
      state  <= PS_D0;
    end else if (wr) begin
      pme_en <= wdata[CSR_EN_BIT];
      state  <= wdata[STATE_W-1:0];
    end
  end
endmodule

// File: rtl/pm_gate.sv
module pm_gate
  import pm_event_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 status,
  input  logic                 dev_en,
  input  logic                 pme_en,
  input  logic [STATE_W-1:0]   state,
  input  logic [N_SUPPORT-1:0] mask,
  input  logic                 acpi_mode,
  input  logic                 isolated,
  output logic                 pme_oe,
  output logic                 io_dec_en,
  output logic                 mem_dec_en
);
  localparam int N_STATES = 1 << STATE_W;

  logic [N_STATES-1:0] allow_vec;
  logic                allowed;
  logic                dec_ok;

  genvar g;
  generate
    for (g = 0; g < N_STATES; g++) begin : g_allow
      if (g == 0) begin : g_d0
        assign allow_vec[g] = mask[g] & ~acpi_mode;
      end else begin : g_dn
        assign allow_vec[g] = mask[g];
      end
    end
  endgenerate

  assign allowed = isolated ? mask[COLD_IDX] : allow_vec[state];
  assign dec_ok  = (state == PS_D0) & ~isolated;

  always_ff @(posedge clk) begin
    if (rst) begin
      pme_oe     <= 1'b0;
      io_dec_en  <= 1'b1;
      mem_dec_en <= 1'b1;
    end else begin
      pme_oe     <= status & dev_en & pme_en & allowed;
      io_dec_en  <= dec_ok;
      mem_dec_en <= dec_ok;
    end
  end
endmodule

// File: rtl/pm_event_ctrl.sv
module pm_event_ctrl
  import pm_event_pkg::*;
#(
  parameter int N_WAKE = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N_WAKE-1:0]    wake_evt,
  input  logic                 dev_pme_en,
  input  logic                 pmcsr_wr,
  input  logic [CSR_W-1:0]     pmcsr_wdata,
  input  logic [N_SUPPORT-1:0] pmc_wake_mask,
  input  logic                 acpi_mode,
  input  logic                 isolated,
  output logic                 pme_oe,
  output logic                 pme_status,
  output logic                 pme_enable,
  output logic [STATE_W-1:0]   pwr_state,
  output logic                 io_dec_en,
  output logic                 mem_dec_en
);
  logic clr_req;

  pm_csr_reg u_csr (
    .clk    (clk),
    .rst    (rst),
    .wr     (pmcsr_wr),
    .wdata  (pmcsr_wdata),
    .pme_en (pme_enable),
    .state  (pwr_state),
    .clr_req(clr_req)
  );

  pm_status_reg #(.N_WAKE(N_WAKE)) u_sts (
    .clk     (clk),
    .rst     (rst),
    .wake_evt(wake_evt),
    .clr_req (clr_req),
    .status  (pme_status)
  );

  pm_gate u_gate (
    .clk       (clk),
    .rst       (rst),
    .status    (pme_status),
    .dev_en    (dev_pme_en),
    .pme_en    (pme_enable),
    .state     (pwr_state),
    .mask      (pmc_wake_mask),
    .acpi_mode (acpi_mode),
    .isolated  (isolated),
    .pme_oe    (pme_oe),
    .io_dec_en (io_dec_en),
    .mem_dec_en(mem_dec_en)
  );
endmodule

// File: rtl/pm_event_chk.sv
module pm_event_chk
  import pm_event_pkg::*;
#(
  parameter int N_WAKE = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic [N_WAKE-1:0]    wake_evt,
  input logic                 dev_pme_en,
  input logic                 pmcsr_wr,
  input logic [CSR_W-1:0]     pmcsr_wdata,
  input logic                 acpi_mode,
  input logic                 isolated,
  input logic                 pme_oe,
  input logic                 pme_status,
  input logic                 pme_enable,
  input logic [STATE_W-1:0]   pwr_state,
  input logic                 io_dec_en
);
  assert_evt_sets_R2: assert property (@(posedge clk) disable iff (rst)
    (|wake_evt) |=> pme_status);

  assert_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    (pme_status && !(pmcsr_wr && pmcsr_wdata[CSR_ST_BIT])) |=> pme_status);

  assert_w1c_R4: assert property (@(posedge clk) disable iff (rst)
    (pmcsr_wr && pmcsr_wdata[CSR_ST_BIT] && !(|wake_evt)) |=> !pme_status);

  assert_csr_load_R5: assert property (@(posedge clk) disable iff (rst)
    pmcsr_wr |=> (pwr_state == $past(pmcsr_wdata[STATE_W-1:0])) &&
                 (pme_enable == $past(pmcsr_wdata[CSR_EN_BIT])));

  assert_oe_gated_R6: assert property (@(posedge clk) disable iff (rst)
    pme_oe |-> ($past(pme_status) && $past(pme_enable) && $past(dev_pme_en)));

  assert_no_acpi_d0_R8: assert property (@(posedge clk) disable iff (rst)
    $past(acpi_mode && pwr_state == PS_D0 && !isolated) |-> !pme_oe);

  assert_dec_d0_only_R9: assert property (@(posedge clk) disable iff (rst)
    io_dec_en |-> $past(pwr_state == PS_D0 && !isolated));
endmodule

bind pm_event_ctrl pm_event_chk #(.N_WAKE(N_WAKE)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wake_evt   (wake_evt),
  .dev_pme_en (dev_pme_en),
  .pmcsr_wr   (pmcsr_wr),
  .pmcsr_wdata(pmcsr_wdata),
  .acpi_mode  (acpi_mode),
  .isolated   (isolated),
  .pme_oe     (pme_oe),
  .pme_status (pme_status),
  .pme_enable (pme_enable),
  .pwr_state  (pwr_state),
  .io_dec_en  (io_dec_en)
);

// File: tb/tb_pm_event_ctrl.sv
module tb_pm_event_ctrl;
  localparam int NW = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [NW-1:0] wake_evt = '0;
  logic        dev_pme_en = 1'b0;
  logic        pmcsr_wr = 1'b0;
  logic [15:0] pmcsr_wdata = '0;
  logic [4:0]  pmc_wake_mask = '0;
  logic        acpi_mode = 1'b0;
  logic        isolated = 1'b0;
  logic        pme_oe, pme_status, pme_enable, io_dec_en, mem_dec_en;
  logic [1:0]  pwr_state;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pm_event_ctrl #(.N_WAKE(NW)) dut (
    .clk(clk), .rst(rst), .wake_evt(wake_evt), .dev_pme_en(dev_pme_en),
    .pmcsr_wr(pmcsr_wr), .pmcsr_wdata(pmcsr_wdata), .pmc_wake_mask(pmc_wake_mask),
    .acpi_mode(acpi_mode), .isolated(isolated), .pme_oe(pme_oe),
    .pme_status(pme_status), .pme_enable(pme_enable), .pwr_state(pwr_state),
    .io_dec_en(io_dec_en), .mem_dec_en(mem_dec_en)
  );

  // Vector: {exp_oe, en, dev, mask[4:0], acpi, iso, state[1:0]}
  localparam int NV = 10;
  localparam logic [11:0] VEC [NV] = '{
    {1'b1, 1'b1, 1'b1, 5'b00001, 1'b0, 1'b0, 2'd0},
    {1'b0, 1'b1, 1'b1, 5'b00001, 1'b1, 1'b0, 2'd0},
    {1'b1, 1'b1, 1'b1, 5'b00010, 1'b0, 1'b0, 2'd1},
    {1'b0, 1'b1, 1'b1, 5'b00010, 1'b0, 1'b0, 2'd2},
    {1'b1, 1'b1, 1'b1, 5'b01000, 1'b0, 1'b0, 2'd3},
    {1'b0, 1'b1, 1'b1, 5'b01000, 1'b0, 1'b1, 2'd3},
    {1'b1, 1'b1, 1'b1, 5'b10000, 1'b0, 1'b1, 2'd3},
    {1'b0, 1'b1, 1'b0, 5'b11111, 1'b0, 1'b0, 2'd0},
    {1'b0, 1'b0, 1'b1, 5'b11111, 1'b0, 1'b0, 2'd0},
    {1'b1, 1'b1, 1'b1, 5'b00100, 1'b1, 1'b0, 2'd2}
  };

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic csr_write(input logic [1:0] st, input logic en, input logic clr);
    @(negedge clk);
    pmcsr_wdata = '0;
    pmcsr_wdata[1:0] = st;
    pmcsr_wdata[8] = en;
    pmcsr_wdata[15] = clr;
    pmcsr_wr = 1'b1;
    @(negedge clk);
    pmcsr_wr = 1'b0;
    pmcsr_wdata = '0;
  endtask

  task automatic pulse_evt(input int idx);
    @(negedge clk);
    wake_evt[idx] = 1'b1;
    @(negedge clk);
    wake_evt = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset values
    chk("R1 status", {7'd0, pme_status}, 8'd0);
    chk("R1 enable", {7'd0, pme_enable}, 8'd0);
    chk("R1 state", {6'd0, pwr_state}, 8'd0);
    chk("R1 oe", {7'd0, pme_oe}, 8'd0);
    chk("R1 dec", {6'd0, io_dec_en, mem_dec_en}, 8'h3);

    // R2 each event source sets status; R4 clear between
    for (int e = 0; e < NW; e++) begin
      pulse_evt(e);
      chk("R2 evt sets status", {7'd0, pme_status}, 8'd1);
      csr_write(2'd0, 1'b0, 1'b1);
      chk("R4 w1c clears", {7'd0, pme_status}, 8'd0);
    end

    // R3 sticky across idle cycles and writes with bit15=0
    pulse_evt(1);
    repeat (4) @(negedge clk);
    chk("R3 sticky idle", {7'd0, pme_status}, 8'd1);
    csr_write(2'd2, 1'b1, 1'b0);
    chk("R3 sticky write", {7'd0, pme_status}, 8'd1);
    // R5 loads
    chk("R5 state", {6'd0, pwr_state}, 8'd2);
    chk("R5 enable", {7'd0, pme_enable}, 8'd1);

    // R6/R7/R8/R9 table walk with status set
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      dev_pme_en    = VEC[v][9];
      pmc_wake_mask = VEC[v][8:4];
      acpi_mode     = VEC[v][3];
      isolated      = VEC[v][2];
      csr_write(VEC[v][1:0], VEC[v][10], 1'b0);
      @(negedge clk);
      chk($sformatf("R6 R7 R8 vec%0d oe", v), {7'd0, pme_oe}, {7'd0, VEC[v][11]});
      chk($sformatf("R9 vec%0d dec", v), {6'd0, io_dec_en, mem_dec_en},
          (VEC[v][1:0] == 2'd0 && !VEC[v][2]) ? 8'h3 : 8'h0);
    end

    // R6 clearing status drops oe one cycle later
    @(negedge clk);
    isolated = 1'b0; acpi_mode = 1'b0; dev_pme_en = 1'b1; pmc_wake_mask = 5'b11111;
    csr_write(2'd1, 1'b1, 1'b0);
    @(negedge clk);
    chk("R6 oe on", {7'd0, pme_oe}, 8'd1);
    csr_write(2'd1, 1'b1, 1'b1);
    chk("R4 cleared", {7'd0, pme_status}, 8'd0);
    @(negedge clk);
    chk("R6 oe off after clear", {7'd0, pme_oe}, 8'd0);

    // R4 event coinciding with clear keeps status
    @(negedge clk);
    wake_evt[2] = 1'b1;
    pmcsr_wdata = 16'h8101;
    pmcsr_wr = 1'b1;
    @(negedge clk);
    wake_evt = '0; pmcsr_wr = 1'b0; pmcsr_wdata = '0;
    chk("R4 event beats clear", {7'd0, pme_status}, 8'd1);

    // R1 reset from D3hot returns to D0
    csr_write(2'd3, 1'b1, 1'b0);
    chk("R5 state D3", {6'd0, pwr_state}, 8'd3);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1 reset to D0", {6'd0, pwr_state}, 8'd0);
    chk("R1 reset dec", {6'd0, io_dec_en, mem_dec_en}, 8'h3);
    chk("R1 reset status", {7'd0, pme_status}, 8'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule